// File: doc/BRIEF.md
# Chip-Select General Output Unit

This unit drives a bank of general-purpose output pins. Each pin can act as an SPI device select or as a plain output. Software changes pin states through a command word. A 1 in the upper half of the word raises a logical output, and a 1 in the lower half lowers it. Bits written as 0 leave their outputs alone. Because of this, one write changes any subset of pins atomically, with no read-modify-write.

A configuration register stores two per-pin fields: a chip-select mode flag and an output-invert flag. Each pin is driven as its logical output XOR its invert flag. The same set and clear commands therefore serve both active-low and active-high selects. For an active-high device, software sets the pin's invert flag; clearing the logical output then drives the pin high, which asserts the device.

A status register returns the logical outputs. The register port is a plain single-cycle write strobe with an address, plus a combinational read path selected by the same address. The port carries no stream data, so it has no valid/ready handshake and never applies back-pressure: every write strobe takes effect at the clock edge on which it is sampled.

Top module: `cs_gpo_unit`

## Requirements
- R1: After reset the configuration register reads 0 (no pin in chip-select mode, none inverted), and every logical output is 1, so every pin is high.
- R2: A write to the command address (1) with bit n (n < 8) set drives logical output n to 0 from the next clock edge.
- R3: A write to the command address with bit 8+n set drives logical output n to 1; writing 0xFF00 makes all eight logical outputs 1.
- R4: Command bits written as 0 leave their logical outputs unchanged, and logical outputs change only on a command write.
- R5: When the set bit (8+n) and the clear bit (n) of one pin are both 1 in a single command write, logical output n becomes 0.
- R6: A write to the configuration address (0) stores the word. Bits [15:8] are the per-pin chip-select mode flags and bits [7:0] are the per-pin invert flags. Reading address 0 returns the stored word.
- R7: Pin n is driven as logical output n XOR invert flag n.
- R8: Reading the status address (2) returns the logical outputs in bits [7:0] with zeros above. The command address reads as 0. Writes to the status address or to address 3 change neither the logical outputs nor the configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 2 | Register address: 0 configuration, 1 command, 2 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| pin_out | output | 8 | Output pin levels |

## Verification
The bench builds the unit with its default of eight pins and a reset level of 1. At that size the full 16-bit command and configuration words are used end to end. Every pin position can be set, cleared and given a set/clear collision, and a mixed invert mask can be applied in the same run. With reset level 1, the check that every pin starts deasserted for active-low devices can be observed directly at the pins.

// File: rtl/cs_gpo_pkg.sv
package cs_gpo_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/cs_gpo_cfg_reg.sv
module cs_gpo_cfg_reg #(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [2*NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0]   csm_q,
  output logic [NUM_PINS-1:0]   inv_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csm_q <= '0;
      inv_q <= '0;
    end else if (we) begin
      csm_q <= wdata[2*NUM_PINS-1:NUM_PINS];
      inv_q <= wdata[NUM_PINS-1:0];
    end
  end
endmodule

// File: rtl/cs_gpo_level_bank.sv
module cs_gpo_level_bank #(
  parameter int   NUM_PINS    = 8,
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [NUM_PINS-1:0] set_bits,
  input  logic [NUM_PINS-1:0] clr_bits,
  output logic [NUM_PINS-1:0] level_q
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        level_q[i] <= RESET_LEVEL;
      else if (we && clr_bits[i])
        level_q[i] <= 1'b0;            // clear has priority
      else if (we && set_bits[i])
        level_q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/cs_gpo_pin_drv.sv
module cs_gpo_pin_drv #(
  parameter int NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0] level,
  input  logic [NUM_PINS-1:0] inv,
  output logic [NUM_PINS-1:0] pin
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign pin[i] = level[i] ^ inv[i];
  end
endmodule

// File: rtl/cs_gpo_unit.sv
module cs_gpo_unit
  import cs_gpo_pkg::*;
#(
  parameter int   NUM_PINS    = 8,
  parameter logic RESET_LEVEL = 1'b1,
  localparam int  DATA_W      = 2 * NUM_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_PINS-1:0] pin_out
);
  logic                cfg_we, cmd_we;
  logic [NUM_PINS-1:0] csm_q, inv_q, level_q;

  assign cfg_we = reg_wr && (reg_addr == ADDR_CFG);
  assign cmd_we = reg_wr && (reg_addr == ADDR_CMD);

  cs_gpo_cfg_reg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(reg_wdata),
    .csm_q(csm_q), .inv_q(inv_q)
  );

  cs_gpo_level_bank #(.NUM_PINS(NUM_PINS), .RESET_LEVEL(RESET_LEVEL)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cmd_we),
    .set_bits(reg_wdata[DATA_W-1:NUM_PINS]),
    .clr_bits(reg_wdata[NUM_PINS-1:0]),
    .level_q(level_q)
  );

  cs_gpo_pin_drv #(.NUM_PINS(NUM_PINS)) u_drv (
    .level(level_q), .inv(inv_q), .pin(pin_out)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CFG:  reg_rdata = {csm_q, inv_q};
      ADDR_STAT: reg_rdata = {{NUM_PINS{1'b0}}, level_q};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cs_gpo_unit_chk.sv
module cs_gpo_unit_chk
  import cs_gpo_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [2*NUM_PINS-1:0] reg_wdata,
  input logic [NUM_PINS-1:0]   level_q,
  input logic [NUM_PINS-1:0]   csm_q,
  input logic [NUM_PINS-1:0]   inv_q
);
  logic                cmd_w, cfg_w;
  logic [NUM_PINS-1:0] set_b, clr_b;
  assign cmd_w = reg_wr && (reg_addr == ADDR_CMD);
  assign cfg_w = reg_wr && (reg_addr == ADDR_CFG);
  assign set_b = reg_wdata[2*NUM_PINS-1:NUM_PINS];
  assign clr_b = reg_wdata[NUM_PINS-1:0];

  a_r2_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w |=> ((level_q & $past(clr_b)) == '0));

  a_r3_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w |=> ((level_q & $past(set_b & ~clr_b)) == $past(set_b & ~clr_b)));

  a_r4_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w |=> ((level_q & ~$past(set_b | clr_b)) == ($past(level_q) & ~$past(set_b | clr_b))));

  a_r4_no_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_w |=> $stable(level_q));

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && ((set_b & clr_b) != '0)) |=> ((level_q & $past(set_b & clr_b)) == '0));

  a_r6_cfg_stores: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_w |=> ({csm_q, inv_q} == $past(reg_wdata)));

  a_r8_cfg_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_w |=> ($stable(csm_q) && $stable(inv_q)));
endmodule

bind cs_gpo_unit cs_gpo_unit_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .level_q(level_q), .csm_q(csm_q), .inv_q(inv_q)
);

// File: tb/cs_gpo_unit_bench.sv
module cs_gpo_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  pin_out;

  cs_gpo_unit u_cs_gpo_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_out(pin_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          sel;   // 0..3 register read, 4 pins
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_level = 8'hFF;
  logic [7:0] m_inv = 8'h00;
  logic [7:0] m_csm = 8'h00;

  // monitor: compare one queued item per cycle, a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        act = (it.sel == 4) ? {8'h00, pin_out} : reg_rdata;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd1) m_level = (m_level | d[15:8]) & ~d[7:0];
    else if (a == 2'd0) begin m_csm = d[15:8]; m_inv = d[7:0]; end
  endtask

  task automatic expect_item(input int sel, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    if (sel < 4) reg_addr = sel[1:0];
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    expect_item(2, {8'h00, m_level}, {tag, " status"});
    expect_item(4, {8'h00, m_level ^ m_inv}, {tag, " pins (R7)"});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_item(0, 16'h0000, "R1 cfg after reset");
    expect_item(2, 16'h00FF, "R1 status after reset");
    expect_item(4, 16'h00FF, "R1 pins after reset");
    // R2 clear all
    wr(2'd1, 16'h00FF);
    check_all("R2 clear all");
    // R3 set all with 0xFF00
    wr(2'd1, 16'hFF00);
    check_all("R3 set all");
    // R4 partial clear, others hold
    wr(2'd1, 16'h0005);
    expect_item(2, 16'h00FA, "R4 partial clear");
    wr(2'd1, 16'h0300);
    expect_item(2, 16'h00FB, "R4 partial set keeps bit2 low");
    wr(2'd1, 16'h0000);
    expect_item(2, 16'h00FB, "R4 zero command no change");
    // R5 collision
    wr(2'd1, 16'h8181);
    expect_item(2, 16'h007A, "R5 clear wins");
    // R6 config
    wr(2'd0, 16'hF00F);
    expect_item(0, 16'hF00F, "R6 cfg readback");
    check_all("R7 mixed invert");
    // R7 active-high select on pin 0
    wr(2'd0, 16'h0101);
    wr(2'd1, 16'h0100);
    expect_item(4, {8'h00, m_level ^ m_inv}, "R7 pin0 deasserted low");
    wr(2'd1, 16'h0001);
    expect_item(4, 16'h007B, "R7 pin0 asserted high");
    // R8 reads and ignored writes
    expect_item(1, 16'h0000, "R8 command reads zero");
    wr(2'd2, 16'hFFFF);
    wr(2'd3, 16'h00FF);
    expect_item(2, {8'h00, m_level}, "R8 status write ignored");
    expect_item(0, 16'h0101, "R8 cfg unaffected");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule